// File: doc/BRIEF.md
# Microprogram Sequencer with Control Store

This block is the control unit of a microcoded processor. It holds a read-only control store of 512 microinstructions, each 36 bits wide. Two registers frame it: a microaddress register that names the word being executed, and a microword register that holds that word. Every clock the microword register drives the control fields of the datapath. At the same time the sequencer works out which microword comes next. No program counter increment is involved. The next address starts from the address field inside the microword. Two ALU status flags can set its top bit, and the fetched instruction byte can be merged into its low bits.

The control store gets its contents from a small built-in microprogram that a package function computes, so no external file is needed. The datapath sends back the negative and zero flags of the current cycle's ALU result, along with the instruction byte it last fetched. Setting the opcode into the low address bits gives a 256-way dispatch in one cycle. Setting a flag into the top bit gives a two-way branch between a pair of addresses 256 apart.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `upc` and every control output (`alu_ctl`, `c_wr`, `mem_ctl`, `b_sel`) are zero after that edge. The microword register holds all zeros, so the first address after reset is 0.
- R2: After each rising edge without reset, `upc` equals the computed next address, and the control outputs equal the fields of the store word at that address. The one exception is the zeroed word that follows a reset.
- R3: Store word at address a (9 bits):
  - `alu_ctl` = a[7:0] XOR 8'h5A
  - `c_wr` = bitwise NOT of a
  - `b_sel` = a[3:0]
  - `mem_ctl` = {a[8]&a[0], a[8]&~a[0], a==0}, meaning bit 2 is write, bit 1 is read and bit 0 is fetch
  - Address 0 has jump field 0 with dispatch set.
  - Address 511 has jump field 9'h10F with dispatch set.
  - Other addresses below 256 have jump field {0,a[7:0]}, negative-branch = a[1] and zero-branch = a[0].
  - Addresses 256 to 510 have jump field 0 and no branch bits.
- R4: With dispatch, negative-branch and zero-branch all clear, the next address is exactly the jump field, with no increment.
- R5: When negative-branch is set and `alu_n` is high, bit 8 of the next address is 1. Otherwise that bit is just the jump field's bit 8, unless R6 sets it.
- R6: When zero-branch is set and `alu_z` is high, bit 8 of the next address is 1.
- R7: When dispatch is set, bits 7:0 of the next address are the jump field's bits 7:0 ORed with `op_byte`. Bit 8 still follows R5 and R6.
- R8: `op_byte` has no effect on the next address when dispatch is clear. `alu_n` and `alu_z` have no effect when their branch bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_n | input | 1 | ALU result negative flag for the current microword |
| alu_z | input | 1 | ALU result zero flag for the current microword |
| op_byte | input | 8 | Fetched instruction byte used for dispatch |
| upc | output | 9 | Microaddress register |
| alu_ctl | output | 8 | ALU and shifter control field |
| c_wr | output | 9 | Register write enables from the result bus |
| mem_ctl | output | 3 | Memory control: {write, read, fetch} |
| b_sel | output | 4 | Operand bus source select |

## Verification
A wrong internal state shows up at the ports the very next edge. A bad microaddress means the outputs carry a different word from the one the bench expects for that address. A wrong jump field, branch bit or dispatch bit sends `upc` to the wrong target one cycle later. After that the error spreads along the path the microprogram takes, so the reference model falls out of step at once. Random flags and opcodes exercise both arms of every branch. The long loop through addresses 255 and 511 also exercises the merge of the dispatch field with the opcode.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int ADDR_W = 9;
  localparam int OP_W   = ADDR_W - 1;
  localparam int ALU_W  = 8;
  localparam int CWR_W  = 9;
  localparam int MEM_W  = 3;
  localparam int BSEL_W = 4;
  localparam int WORD_W = ADDR_W + 3 + ALU_W + CWR_W + MEM_W + BSEL_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic              jmpc;
    logic              jamn;
    logic              jamz;
    logic [ALU_W-1:0]  alu;
    logic [CWR_W-1:0]  cwr;
    logic [MEM_W-1:0]  mem;
    logic [BSEL_W-1:0] bsel;
  } uword_t;

  // Built-in microprogram: dispatch at 0, flag loops below 256,
  // returns to dispatch above, second dispatch with offset at the top.
  function automatic uword_t store_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    w.alu  = ALU_W'(a) ^ ALU_W'(8'h5A);
    w.cwr  = CWR_W'(~a);
    w.bsel = BSEL_W'(a);
    w.mem  = {a[ADDR_W-1] & a[0], a[ADDR_W-1] & ~a[0], a == '0};
    if (a == '0) begin
      w.nxt = '0;
      {w.jmpc, w.jamn, w.jamz} = 3'b100;
    end else if (a == '1) begin
      w.nxt = ADDR_W'(9'h10F);
      {w.jmpc, w.jamn, w.jamz} = 3'b100;
    end else if (!a[ADDR_W-1]) begin
      w.nxt = {1'b0, a[OP_W-1:0]};
      {w.jmpc, w.jamn, w.jamz} = {1'b0, a[1], a[0]};
    end else begin
      w.nxt = '0;
      {w.jmpc, w.jamn, w.jamz} = 3'b000;
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_store.sv
`timescale 1ns/1ps
module useq_store
  import useq_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output uword_t        word_q
);
  localparam int N_WORDS = 1 << AW;

  logic [WORD_W-1:0] rom [N_WORDS];

  initial begin
    for (int i = 0; i < N_WORDS; i++) begin
      rom[i] = store_word(ADDR_W'(i));
    end
  end

  // Synchronous read with output register reset
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= rom[rd_addr];
  end
endmodule

// File: rtl/useq_next.sv
`timescale 1ns/1ps
module useq_next
  import useq_pkg::*;
(
  input  uword_t            cur,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic [OP_W-1:0]   op,
  output logic [ADDR_W-1:0] nxt
);
  logic hi_bit;
  logic [OP_W-1:0] lo_bits;

  always_comb begin
    hi_bit  = cur.nxt[ADDR_W-1] | (cur.jamn & flag_n) | (cur.jamz & flag_z);
    lo_bits = cur.nxt[OP_W-1:0];
    if (cur.jmpc) lo_bits = lo_bits | op;
    nxt = {hi_bit, lo_bits};
  end
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              alu_n,
  input  logic              alu_z,
  input  logic [OP_W-1:0]   op_byte,
  output logic [ADDR_W-1:0] upc,
  output logic [ALU_W-1:0]  alu_ctl,
  output logic [CWR_W-1:0]  c_wr,
  output logic [MEM_W-1:0]  mem_ctl,
  output logic [BSEL_W-1:0] b_sel
);
  uword_t            mir;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] mpc;

  useq_next u_next (
    .cur    (mir),
    .flag_n (alu_n),
    .flag_z (alu_z),
    .op     (op_byte),
    .nxt    (nxt_addr)
  );

  useq_store #(.AW(ADDR_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (nxt_addr),
    .word_q  (mir)
  );

  always_ff @(posedge clk) begin
    if (rst) mpc <= '0;
    else     mpc <= nxt_addr;
  end

  assign upc     = mpc;
  assign alu_ctl = mir.alu;
  assign c_wr    = mir.cwr;
  assign mem_ctl = mir.mem;
  assign b_sel   = mir.bsel;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (upc == '0 && alu_ctl == '0 && c_wr == '0 && mem_ctl == '0 && b_sel == '0));

  a_r4_plain_jump: assert property (@(posedge clk) disable iff (rst)
    (!mir.jmpc && !mir.jamn && !mir.jamz) |=> (upc == $past(mir.nxt)));

  a_r5_neg_branch: assert property (@(posedge clk) disable iff (rst)
    (mir.jamn && alu_n) |=> upc[ADDR_W-1]);

  a_r6_zero_branch: assert property (@(posedge clk) disable iff (rst)
    (mir.jamz && alu_z) |=> upc[ADDR_W-1]);

  a_r7_dispatch: assert property (@(posedge clk) disable iff (rst)
    mir.jmpc |=> ((upc[OP_W-1:0] & $past(op_byte)) == $past(op_byte)));
endmodule

// File: tb/sim_useq_top.sv
`timescale 1ns/1ps
module sim_useq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       alu_n = 1'b0;
  logic       alu_z = 1'b0;
  logic [7:0] op_byte = 8'h00;
  logic [8:0] upc;
  logic [7:0] alu_ctl;
  logic [8:0] c_wr;
  logic [2:0] mem_ctl;
  logic [3:0] b_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  useq_top u0 (
    .clk(clk), .rst(rst), .alu_n(alu_n), .alu_z(alu_z), .op_byte(op_byte),
    .upc(upc), .alu_ctl(alu_ctl), .c_wr(c_wr), .mem_ctl(mem_ctl), .b_sel(b_sel)
  );

  always #10 clk = ~clk;

  // Reference model state: expected outputs and the current word's sequencing fields
  int e_upc, e_alu, e_cw, e_mem, e_bs;
  int w_jf, w_dsp, w_bn, w_bz;
  string tag_upc = "R1";

  task automatic fill(input int a);
    e_alu = (a & 255) ^ 'h5A;
    e_cw  = (~a) & 511;
    e_bs  = a & 15;
    e_mem = (a == 0) ? 1 : (a >= 256 ? ((a % 2 == 1) ? 4 : 2) : 0);
    if (a == 0) begin
      w_jf = 0; w_dsp = 1; w_bn = 0; w_bz = 0;
    end else if (a == 511) begin
      w_jf = 'h10F; w_dsp = 1; w_bn = 0; w_bz = 0;
    end else if (a < 256) begin
      w_jf = a; w_dsp = 0; w_bn = (a / 2) % 2; w_bz = a % 2;
    end else begin
      w_jf = 0; w_dsp = 0; w_bn = 0; w_bz = 0;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      e_upc = 0; e_alu = 0; e_cw = 0; e_mem = 0; e_bs = 0;
      w_jf = 0; w_dsp = 0; w_bn = 0; w_bz = 0;
      tag_upc = "R1";
    end else begin
      int top;
      int low;
      top = (w_jf >= 256) || (w_bn == 1 && alu_n) || (w_bz == 1 && alu_z);
      low = w_jf & 255;
      if (w_dsp == 1) begin
        low = low | int'(op_byte);
        tag_upc = "R7";
      end else if (w_bn == 1 || w_bz == 1)
        tag_upc = (w_bn == 1) ? "R5" : "R6";
      else
        tag_upc = "R4 R8";
      e_upc = top * 256 + low;
      fill(e_upc);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string rtag);
    check(rtag == "" ? tag_upc : rtag, "upc", int'(upc), e_upc);
    check("R2 R3", "alu_ctl", int'(alu_ctl), e_alu);
    check("R2 R3", "c_wr", int'(c_wr), e_cw);
    check("R2 R3", "mem_ctl", int'(mem_ctl), e_mem);
    check("R2 R3", "b_sel", int'(b_sel), e_bs);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    // Directed: drive through dispatch 0 -> FF -> 1FF -> dispatch with offset
    op_byte = 8'hFF; alu_n = 1'b1; alu_z = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      compare_all("");
    end
    // Directed: zero flag only, opcode with sparse bits
    op_byte = 8'h21; alu_n = 1'b0; alu_z = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      compare_all("");
    end
    // Random flags and opcodes
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      compare_all("");
      alu_n = 1'($urandom);
      alu_z = 1'($urandom);
      op_byte = 8'($urandom);
      if (i == 1500) rst = 1'b1;
      if (i == 1502) rst = 1'b0;
    end
    // Mid-run reset check
    rst = 1'b1;
    @(negedge clk);
    compare_all("R1");
    rst = 1'b0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      compare_all("");
      op_byte = 8'($urandom);
      alu_n = 1'($urandom);
      alu_z = 1'($urandom);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #(20 * 100000);
    join_any
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule